// File: doc/BRIEF.md
# Galois-Form Maximal-Length Sequence Generator

This block is an n-bit pseudo-random sequence generator built in the internal-XOR (Galois) form. The register shifts toward its most significant end on every enabled clock. The bit that leaves the top is fed back in two ways: it goes straight into bit 0, and it goes into a two-input XOR in front of every bit position whose polynomial coefficient is set. The polynomial is a parameter. When that polynomial is primitive, the register visits every non-zero state exactly once per period of 2^n − 1 steps. The order of those states is the sequence of successive powers of x in GF(2^n).

Each XOR has exactly two inputs and no XOR feeds another, so the path between flops is one gate deep for any width. A seed can be loaded at any time, and a load wins over a step in the same cycle. The all-zero state would lock the register, so a zero seed is replaced by the value 0…01. Typical uses are fast counters whose count order does not matter, test-pattern sources and scrambler seeds.

Top module: `galois_lfsr`

## Requirements
- R1: While rst_n is low, and after rst_n is released, the state reads 0…01 (only bit 0 set) until the first load or step.
- R2: On a step (step_en=1, load_en=0) with state bit WIDTH−1 equal to 0, the next state is the old state shifted left by one place with a 0 entering bit 0.
- R3: On a step with state bit WIDTH−1 equal to 1, the next state is the old state shifted left by one place, then XORed with TAPS. TAPS bit k (k≥1) is the coefficient of x^k, and TAPS bit 0 is the constant term, which is 1, so bit 0 of the result is 1.
- R4: With step_en=0 and load_en=0 the state holds its value.
- R5: With load_en=1 and a non-zero load_val, the state takes load_val on that clock.
- R6: With load_en=1 and load_val equal to zero, the state becomes 0…01 instead.
- R7: When load_en and step_en are both 1, the load applies and the step does not.
- R8: With the default WIDTH=4 and TAPS=4'b0011 (x^4+x+1), starting from 0001 the state runs 0001, 0010, 0100, 1000, 0011, 0110, 1100, 1011, 0101, 1010, 0111, 1110, 1111, 1101, 1001 and then returns to 0001.
- R9: The state is never all zeros once out of reset.
- R10: With WIDTH=8 and TAPS=8'b00011101 (x^8+x^4+x^3+x^2+1), the state returns to 0x01 after exactly 255 steps and reaches no earlier repeat of 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| step_en | input | 1 | Advance the sequence by one state |
| load_en | input | 1 | Load strobe for load_val; takes priority over step_en |
| load_val | input | WIDTH | Seed value; zero is replaced by 0…01 |
| state | output | WIDTH | Full register contents |

## Verification
The bench checks the whole 4-bit period against the listed order. A tap placed one position off, or a feedback bit that skips bit 0, would break that order within a few steps. It loads a zero seed, which a design without the guard would lock at zero forever. It also raises the load and the step together, where a design with the wrong priority would end one state past the seed. The 8-bit run counts the period, so a wrong or missing tap shows up as a cycle shorter than 255 steps. Hold cycles check that the state does not drift while step_en is low.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2
  } lfsr_src_e;
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned       WIDTH = 4,
  parameter logic [WIDTH-1:0]  TAPS  = 4'b0011
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic fb;
  assign fb     = cur[WIDTH-1];
  assign nxt[0] = fb;

  for (genvar k = 1; k < WIDTH; k++) begin : g_bit
    if (TAPS[k]) begin : g_tap
      assign nxt[k] = cur[k-1] ^ fb;
    end else begin : g_wire
      assign nxt[k] = cur[k-1];
    end
  end
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] safe
);
  localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);
  always_comb begin
    if (seed == '0) safe = UNIT;
    else            safe = seed;
  end
endmodule

// File: rtl/galois_lfsr.sv
module galois_lfsr
  import lfsr_pkg::*;
#(
  parameter int unsigned       WIDTH = 4,
  parameter logic [WIDTH-1:0]  TAPS  = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);

  logic [WIDTH-1:0] q_r, q_nxt, shifted, seed_ok;
  lfsr_src_e        src;

  lfsr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .cur(q_r),
    .nxt(shifted)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
    .seed(load_val),
    .safe(seed_ok)
  );

  always_comb begin
    if (load_en)      src = SRC_LOAD;
    else if (step_en) src = SRC_STEP;
    else              src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_LOAD: q_nxt = seed_ok;
      SRC_STEP: q_nxt = shifted;
      default:  q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= UNIT;
    else        q_r <= q_nxt;
  end

  assign state = q_r;

  AST_RESET_UNIT: assert property (@(posedge clk) !rst_n |=> state == UNIT); // R1
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !load_en && !state[WIDTH-1] |=> state == {$past(state[WIDTH-2:0]), 1'b0}); // R2
  AST_FEED_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !load_en && state[WIDTH-1] |=> state[0]); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !load_en |=> $stable(state)); // R4
  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && load_val != '0 |=> state == $past(load_val)); // R5 R7
  AST_ZERO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && load_val == '0 |=> state == UNIT); // R6
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R9
endmodule

// File: tb/galois_lfsr_test.sv
module galois_lfsr_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en, load_en;
  logic [3:0] load_val;
  logic [3:0] state;
  logic       s8_en;
  logic [7:0] state8;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [3:0] val; string tag; } exp_t;
  exp_t sb[$];
  logic [3:0] model;

  always #5 clk = ~clk;

  galois_lfsr uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
    .load_val(load_val), .state(state)
  );

  galois_lfsr #(.WIDTH(8), .TAPS(8'b00011101)) uut8 (
    .clk(clk), .rst_n(rst_n), .step_en(s8_en), .load_en(1'b0),
    .load_val(8'h00), .state(state8)
  );

  function automatic logic [3:0] ref_step(logic [3:0] s);
    return {s[2:0], 1'b0} ^ (s[3] ? 4'b0011 : 4'b0000);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: sets inputs away from the edge and pushes the expected state
  task automatic drive(logic en, logic ld, logic [3:0] seed, string tag);
    @(negedge clk);
    step_en = en; load_en = ld; load_val = seed;
    if (ld)      model = (seed == 4'h0) ? 4'h1 : seed;
    else if (en) model = ref_step(model);
    sb.push_back('{model, tag});
    @(posedge clk);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, {4'h0, state}, {4'h0, e.val});
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] seq [15] = '{4'h1,4'h2,4'h4,4'h8,4'h3,4'h6,4'hC,4'hB,
                             4'h5,4'hA,4'h7,4'hE,4'hF,4'hD,4'h9};
    step_en = 0; load_en = 0; load_val = 0; s8_en = 0; rst_n = 0;
    model = 4'h1;
    repeat (3) @(negedge clk);
    check("R1 reset value", {4'h0, state}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {4'h0, state}, 8'h01);

    // R8 full period against the stated order, covers R2 R3 R9
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk); step_en = 1; load_en = 0;
      @(negedge clk); step_en = 0;
      check($sformatf("R8 step %0d", i), {4'h0, state}, {4'h0, seq[i % 15]});
      if (state == 4'h0) check("R9 nonzero", 8'h00, 8'h01);
    end
    model = state;

    drive(0, 0, 4'h0, "R4 hold");
    drive(0, 0, 4'h7, "R4 hold seed ignored");
    drive(0, 1, 4'h6, "R5 load");
    drive(1, 0, 4'h0, "R2 shift msb0");
    drive(1, 0, 4'h0, "R3 shift msb1");
    drive(0, 1, 4'h0, "R6 zero seed");
    drive(1, 0, 4'h0, "R6 step after guard");
    drive(1, 1, 4'h9, "R7 load over step");
    drive(1, 0, 4'h0, "R3 from 1001");
    drive(1, 1, 4'h0, "R7 R6 zero with step");
    drive(0, 0, 4'h0, "R4 hold end");
    @(negedge clk); step_en = 0; load_en = 0;
    repeat (2) @(negedge clk);

    // R10 8-bit period
    begin
      int period = 0;
      bit zero_seen = 0;
      s8_en = 1;
      do begin
        @(negedge clk);
        period++;
        if (state8 == 8'h00) zero_seen = 1;
      end while (state8 != 8'h01 && period < 400);
      s8_en = 0;
      check("R10 period 255", 8'(period), 8'd255);
      check("R9 8-bit never zero", {7'h0, zero_seen}, 8'h00);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule